// File: doc/BRIEF.md
# Streamed Two-Word Colour Curve Table Port

This block holds a colour-adjustment curve of 384 entries. Every entry pairs a 12-bit first curve point with a 32-bit second curve point. Software reaches the table through a small 32-bit register window. It never addresses an entry directly. An internal pointer selects the entry, and software moves that pointer with control bits carried in the same word as the first-point data. To load the table, software stages the second point in one register and then writes the first point to a second register. That second write stores both halves and steps the pointer. To read the table back, software sets a read mode and fetches the entries in the same order.

Next to the table sit two more registers. One is a 32-bit zone threshold. The other is a mode register whose three top bits decide whether the table acts on hue, saturation or value. A combinational lookup port lets the pixel path see any entry together with the threshold and the three enables.

Top module: `lut_stream_port`

## Requirements
- R1: After reset the pointer is at entry 0 in write mode. The read data, the threshold and the three enables are all zero, so a data-0 write straight after reset stores into entry 0.
- R2: A write to data-1 (byte offset 0x4) only loads a staging word. The table and the pointer do not change.
- R3: A data-0 write (offset 0x0) with bit 26 set and bit 25 clear does three things. It stores bits 11:0 and the staged word into entry 0, sets the pointer to 1 and selects write mode.
- R4: A data-0 write with bit 26 clear stores bits 11:0 and the staged word at the pointer and advances the pointer by one. It leaves read mode if that mode was active, and it never resets the pointer. Bit 25 has no effect in this case.
- R5: The pointer wraps from 383 to 0, both on writes and on read-mode reads.
- R6: A data-0 write with bits 25 and 26 both set selects read mode and sets the pointer to 0. It leaves the table unchanged.
- R7: Read data appears on the cycle after the read strobe. A data-1 read returns the full second point at the pointer and never moves the pointer. A data-0 read returns the first point zero-extended to 32 bits. A data-0 read advances the pointer only in read mode.
- R8: The threshold register at offset 0x8 is read and written as a full 32-bit word and appears on `zone_thresh`.
- R9: The mode register is at offset 0xC. Bit 29 drives `hue_en`, bit 30 drives `sat_en` and bit 31 drives `val_en`. A read of this register returns those three bits and zeros elsewhere.
- R10: A data-0 read and a data-0 write can land in the same cycle. The read returns the entry as it was before the write, and the pointer moves only as the write dictates, one step at most.
- R11: The lookup port shows the entry selected by `lk_idx` with no clock delay. A stored entry is visible there from the cycle after its commit. An index of 384 or more reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte address; bits 3:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| lk_idx | input | 9 | Lookup entry index |
| lk_p0 | output | 12 | First curve point of the looked-up entry |
| lk_p1 | output | 32 | Second curve point of the looked-up entry |
| hue_en | output | 1 | Table acts on hue |
| sat_en | output | 1 | Table acts on saturation |
| val_en | output | 1 | Table acts on value |
| zone_thresh | output | 32 | Zone threshold word |

## Verification
Two functions can fall in the same cycle: a read-mode fetch of data-0, which would step the pointer, and a data-0 write, which commits and also steps or resets the pointer. The bench raises both strobes on offset 0x0 together, both in a directed case after read mode has moved the pointer and at random during the mixed phase. It judges the result three ways. The returned word must match the entry before the write. The committed entry must sit at the old pointer. A following data-1 read must show the pointer moved exactly once.

// File: rtl/lut_stream_port.sv
module lut_stream_port #(
  parameter int DEPTH  = 384,
  parameter int P0_W   = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [P0_W-1:0]   lk_p0,
  output logic [DATA_W-1:0] lk_p1,
  output logic              hue_en,
  output logic              sat_en,
  output logic              val_en,
  output logic [DATA_W-1:0] zone_thresh
);
  localparam int HOME_BIT = 26;
  localparam int READ_BIT = 25;
  localparam int HUE_BIT  = 29;
  localparam int SAT_BIT  = 30;
  localparam int VAL_BIT  = 31;
  localparam logic [1:0] SEL_D0 = 2'd0, SEL_D1 = 2'd1, SEL_TH = 2'd2, SEL_MD = 2'd3;

  logic [P0_W-1:0]   tbl_p0 [DEPTH];
  logic [DATA_W-1:0] tbl_p1 [DEPTH];
  logic [IDX_W-1:0]  idx, idx_next, put_idx;
  logic [DATA_W-1:0] stage;
  logic              rd_mode;
  logic [1:0]        sel;
  logic              wr_d0, wr_d1, wr_th, wr_md, rd_d0;
  logic              go_home, go_read, commit;

  assign sel     = bus_addr[3:2];
  assign wr_d0   = bus_wr && sel == SEL_D0;
  assign wr_d1   = bus_wr && sel == SEL_D1;
  assign wr_th   = bus_wr && sel == SEL_TH;
  assign wr_md   = bus_wr && sel == SEL_MD;
  assign rd_d0   = bus_rd && sel == SEL_D0;
  assign go_home = bus_wdata[HOME_BIT];
  assign go_read = go_home && bus_wdata[READ_BIT];
  assign commit  = wr_d0 && !go_read;
  assign put_idx = go_home ? '0 : idx;
  assign idx_next = (idx == IDX_W'(DEPTH - 1)) ? '0 : idx + 1'b1;

  always_ff @(posedge clk) begin
    if (commit) begin
      tbl_p0[put_idx] <= bus_wdata[P0_W-1:0];
      tbl_p1[put_idx] <= stage;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx     <= '0;
      rd_mode <= 1'b0;
    end else if (wr_d0) begin
      rd_mode <= go_read;
      if (go_read)      idx <= '0;
      else if (go_home) idx <= (DEPTH > 1) ? IDX_W'(1) : '0;
      else              idx <= idx_next;
    end else if (rd_d0 && rd_mode) begin
      idx <= idx_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage       <= '0;
      zone_thresh <= '0;
      hue_en      <= 1'b0;
      sat_en      <= 1'b0;
      val_en      <= 1'b0;
    end else begin
      if (wr_d1) stage <= bus_wdata;
      if (wr_th) zone_thresh <= bus_wdata;
      if (wr_md) begin
        hue_en <= bus_wdata[HUE_BIT];
        sat_en <= bus_wdata[SAT_BIT];
        val_en <= bus_wdata[VAL_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (sel)
        SEL_D0: bus_rdata[P0_W-1:0] <= tbl_p0[idx];
        SEL_D1: bus_rdata <= tbl_p1[idx];
        SEL_TH: bus_rdata <= zone_thresh;
        default: begin
          bus_rdata[HUE_BIT] <= hue_en;
          bus_rdata[SAT_BIT] <= sat_en;
          bus_rdata[VAL_BIT] <= val_en;
        end
      endcase
    end
  end

  assign lk_p0 = (int'(lk_idx) < DEPTH) ? tbl_p0[lk_idx] : '0;
  assign lk_p1 = (int'(lk_idx) < DEPTH) ? tbl_p1[lk_idx] : '0;
endmodule

// File: rtl/lut_stream_port_chk.sv
module lut_stream_port_chk #(
  parameter int DEPTH = 384,
  parameter int ADDR_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [IDX_W-1:0]  idx,
  input logic              rd_mode,
  input logic              hue_en,
  input logic              sat_en,
  input logic              val_en,
  input logic [31:0]       zone_thresh
);
  logic w0, w1, r0, r1, wt, wm;
  assign w0 = bus_wr && bus_addr[3:2] == 2'd0;
  assign w1 = bus_wr && bus_addr[3:2] == 2'd1;
  assign wt = bus_wr && bus_addr[3:2] == 2'd2;
  assign wm = bus_wr && bus_addr[3:2] == 2'd3;
  assign r0 = bus_rd && bus_addr[3:2] == 2'd0;
  assign r1 = bus_rd && bus_addr[3:2] == 2'd1;

  // R2
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w1 |=> $stable(idx) && $stable(rd_mode));
  // R3
  idx_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w0 && bus_wdata[26] && !bus_wdata[25] |=> idx == IDX_W'(1) && !rd_mode);
  // R4
  commit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w0 && !bus_wdata[26] && int'(idx) < DEPTH - 1 |=> idx == $past(idx) + 1'b1 && !rd_mode);
  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w0 && !bus_wdata[26] || !bus_wr && r0 && rd_mode) && int'(idx) == DEPTH - 1 |=> idx == '0);
  // R6
  rd_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w0 && bus_wdata[26] && bus_wdata[25] |=> idx == '0 && rd_mode);
  // R7
  rd_d1_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r1 && !bus_wr |=> $stable(idx));
  // R7
  rd_d0_wmode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r0 && !bus_wr && !rd_mode |=> $stable(idx));
  // R10
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r0 && w0 && rd_mode && !bus_wdata[26] && int'(idx) < DEPTH - 1 |=> idx == $past(idx) + 1'b1);
  // R8
  thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wt |=> zone_thresh == $past(bus_wdata));
  // R9
  mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wm |=> {val_en, sat_en, hue_en} == $past(bus_wdata[31:29]));
  // R9
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wm |=> $stable({val_en, sat_en, hue_en}));
endmodule

bind lut_stream_port lut_stream_port_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .idx(idx), .rd_mode(rd_mode), .hue_en(hue_en),
  .sat_en(sat_en), .val_en(val_en), .zone_thresh(zone_thresh));

// File: tb/lut_stream_port_tb.sv
module lut_stream_port_tb;
  localparam int DEPTH = 384;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, lk_p1, zone_thresh;
  logic [8:0] lk_idx = '0;
  logic [11:0] lk_p0;
  logic hue_en, sat_en, val_en;
  int n_cmp = 0, n_bad = 0;

  logic [11:0] m_p0 [DEPTH];
  logic [31:0] m_p1 [DEPTH];
  int m_idx = 0;
  bit m_rdm = 0;
  logic [31:0] m_stage = 0, m_thr = 0;
  logic [2:0] m_mode = 0;

  always #5 clk = ~clk;

  lut_stream_port u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lk_idx(lk_idx),
    .lk_p0(lk_p0), .lk_p1(lk_p1), .hue_en(hue_en), .sat_en(sat_en), .val_en(val_en),
    .zone_thresh(zone_thresh));

  function automatic int nxt(int i);
    return (i == DEPTH - 1) ? 0 : i + 1;
  endfunction

  function automatic logic [31:0] expect_rd(int off);
    case (off)
      0: return {20'b0, m_p0[m_idx]};
      1: return m_p1[m_idx];
      2: return m_thr;
      default: return {m_mode, 29'b0};
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(bit w, bit r, int off, logic [31:0] wd);
    logic [31:0] exp_r;
    string tag;
    exp_r = expect_rd(off);
    tag = (w && r && off == 0) ? "R10" : (off == 2) ? "R8" : (off == 3) ? "R9" : "R7";
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = 4'(off << 2); bus_wdata = wd;
    if (w) begin
      case (off)
        1: m_stage = wd;
        2: m_thr = wd;
        3: m_mode = wd[31:29];
        default: begin
          if (wd[26] && wd[25]) begin m_rdm = 0; m_idx = 0; m_rdm = 1; end
          else begin
            if (wd[26]) m_idx = 0;
            m_p0[m_idx] = wd[11:0];
            m_p1[m_idx] = m_stage;
            m_idx = nxt(m_idx);
            m_rdm = 0;
          end
        end
      endcase
    end else if (r && off == 0 && m_rdm) m_idx = nxt(m_idx);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    if (r) chk(tag, bus_rdata, exp_r);
    chk("R9", {29'b0, val_en, sat_en, hue_en}, {29'b0, m_mode});
    chk("R8", zone_thresh, m_thr);
  endtask

  task automatic lk_chk(string tag, int i);
    lk_idx = 9'(i);
    #1;
    chk(tag, {20'b0, lk_p0}, (i < DEPTH) ? {20'b0, m_p0[i]} : 32'b0);
    chk(tag, lk_p1, (i < DEPTH) ? m_p1[i] : 32'b0);
  endtask

  function automatic logic [31:0] plain(logic [31:0] v);
    return v & ~32'h0600_0000;
  endfunction

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1A7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", bus_rdata, 0);
    chk("R1", {29'b0, val_en, sat_en, hue_en}, 0);
    chk("R1", zone_thresh, 0);
    op(1, 0, 1, 32'hDEAD_0001);
    op(1, 0, 0, 32'h0000_0ABC);
    lk_chk("R1", 0);

    // R3 / R4 full load starting with the home bit
    op(1, 0, 1, $urandom);
    op(1, 0, 0, plain($urandom) | 32'h0400_0000);
    for (int i = 1; i < DEPTH; i++) begin
      op(1, 0, 1, $urandom);
      op(1, 0, 0, plain($urandom));
    end
    for (int i = 0; i < DEPTH; i++) lk_chk((i == 0) ? "R3" : "R4", i);
    // R5 wrap on write: pointer back at 0
    op(1, 0, 1, 32'h1234_5678);
    op(1, 0, 0, 32'h0000_0321);
    lk_chk("R5", 0);
    lk_chk("R5", 1);
    // R11 out-of-range lookup
    lk_chk("R11", 400);
    lk_chk("R11", 511);

    op(1, 0, 2, 32'hA5A5_0F0F);
    op(0, 1, 2, 0);

    // R6 read mode leaves table alone
    op(1, 0, 0, 32'h0600_0ABC);
    lk_chk("R6", 0);
    for (int i = 0; i < DEPTH; i++) begin
      op(0, 1, 1, 0);
      op(0, 1, 0, 0);
    end
    // R5 read wrap, R7 data-1 read does not advance
    op(0, 1, 1, 0);
    op(0, 1, 1, 0);
    // R2 staging does not touch table or read order
    op(1, 0, 1, 32'hFACE_B00C);
    op(0, 1, 1, 0);
    lk_chk("R2", 0);
    for (int i = 0; i < 5; i++) op(0, 1, 0, 0);
    // R4 leave read mode without pointer reset, bit 25 ignored
    op(1, 0, 0, 32'h0200_0777);
    lk_chk("R4", 5);
    lk_chk("R4", 0);
    op(0, 1, 1, 0);

    // R10 directed collision
    op(1, 0, 0, 32'h0600_0000);
    op(0, 1, 0, 0);
    op(1, 0, 1, 32'h0BAD_CAFE);
    op(1, 1, 0, 32'h0000_0111);
    lk_chk("R10", 1);
    op(0, 1, 1, 0);
    op(0, 1, 0, 0);
    op(0, 1, 0, 0);

    // R9 mode bits
    op(1, 0, 3, 32'hA000_0000);
    op(0, 1, 3, 0);
    op(1, 0, 3, 32'h5FFF_FFFF);
    op(0, 1, 3, 0);

    // mixed random phase
    for (int n = 0; n < 3000; n++) begin
      int pick;
      pick = $urandom_range(0, 99);
      if (pick < 20)      op(1, 0, 1, $urandom);
      else if (pick < 40) op(1, 0, 0, plain($urandom));
      else if (pick < 43) op(1, 0, 0, 32'h0600_0000 | ($urandom & 32'hFFF));
      else if (pick < 45) op(1, 0, 0, plain($urandom) | 32'h0400_0000);
      else if (pick < 65) op(0, 1, 0, 0);
      else if (pick < 78) op(0, 1, 1, 0);
      else if (pick < 84) op(1, 1, 0, plain($urandom));
      else if (pick < 88) op(1, 0, 2, $urandom);
      else if (pick < 91) op(1, 0, 3, $urandom);
      else if (pick < 95) op(0, 1, $urandom_range(2, 3), 0);
      else lk_chk("R11", $urandom_range(0, DEPTH - 1));
    end
    for (int i = 0; i < DEPTH; i += 7) lk_chk("R11", i);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule